// File: doc/BRIEF.md
# Bit-Field Insert Execution Unit

This unit runs one stage of a 32-bit bit-field insert instruction in an execution pipeline. Each cycle it can take an instruction word with a valid strobe, together with operand values that were already read from the register file: three 32-bit data operands and one 64-bit register pair. It works out which of four insert encodings the word holds and picks the insert source, the field width and the field position for that encoding. It then builds a field mask, copies the base operand with the field cleared, and puts the shifted source into the field.

The result, the destination register index and two flags are registered, so they appear one clock after the request. One flag marks a field that runs past bit 31. The other marks a word whose opcode or secondary opcode is not a known insert encoding. Reading the register file, hazard handling and writeback are done by the pipeline around the unit.

Top module: `bfins_unit`

## Requirements
- R1: Opcode 0xB7 in bits [7:0], with 00 in bits [22:21]: position = bits [27:23], width = bits [20:16], source = bits [15:12] zero-extended. The result is (op_a & ~mask) | ((src << pos) & mask), where mask = (2^width - 1) << pos.
- R2: Opcode 0x37, with 00 in bits [22:21]: position and width are taken from the same bits as in R1, and the source is op_b. Bits [15:12] hold the index of op_b and do not change the result.
- R3: Opcode 0x97, with 000 in bits [23:21]: width = op_e[36:32], position = op_e[4:0], source = bits [15:12] zero-extended. Bits [20:16] have no effect on the result.
- R4: Opcode 0xD7, with 000 in bits [23:21]: position = op_d[4:0], width = bits [20:16], source = bits [15:12] zero-extended. op_d[31:5] has no effect on the result.
- R5: A width of 0 gives an empty mask, and the result equals op_a for every position.
- R6: res_oor is 1 exactly when position + width > 32. The result is then the R1 formula truncated to 32 bits.
- R7: Any other opcode, or a nonzero secondary field, sets res_illegal for one cycle and keeps res_valid low.
- R8: res_valid follows in_valid (on a legal word) by exactly one clock. res_dest carries bits [31:28] of that word.
- R9: While rst_n is low at a clock edge, res_valid, res_illegal and res_oor are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | Base operand |
| op_b | input | 32 | Register insert source |
| op_d | input | 32 | Register that supplies the position |
| op_e | input | 64 | Register pair that supplies the width and the position |
| res_valid | output | 1 | Registered result is valid |
| res_data | output | 32 | Merged result |
| res_dest | output | 4 | Destination register index |
| res_oor | output | 1 | Position plus width exceeded 32 |
| res_illegal | output | 1 | Word was not a recognized insert encoding |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and the shift-based mask builder. With these, all 1024 pairs of 5-bit position and width can be swept. That sweep is run for every format, with random base and source values, so each overflow boundary, each zero-width case and each field that touches bit 31 is checked against a reference computed with 64-bit arithmetic. The directed cases cover illegal opcodes, nonzero secondary fields, the inputs that must be ignored, and the reset behaviour.

// File: rtl/bfins_pkg.sv
package bfins_pkg;
    localparam int INSTR_W = 32;
    localparam int FLD_W   = 5;
    localparam int IDX_W   = 4;

    localparam logic [7:0] OPC_IMM_PW   = 8'hB7;
    localparam logic [7:0] OPC_IMM_PAIR = 8'h97;
    localparam logic [7:0] OPC_IMM_RW   = 8'hD7;
    localparam logic [7:0] OPC_REG_PW   = 8'h37;

    typedef enum logic [2:0] {
        FMT_IMM_PW,
        FMT_IMM_PAIR,
        FMT_IMM_RW,
        FMT_REG_PW,
        FMT_NONE
    } fmt_e;
endpackage

// File: rtl/bfins_decode.sv
module bfins_decode
    import bfins_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [DATA_W-1:0]  op_d,
    input  logic [PAIR_W-1:0]  op_e,
    output logic               legal,
    output fmt_e               fmt,
    output logic [DATA_W-1:0]  src,
    output logic [FLD_W-1:0]   pos,
    output logic [FLD_W-1:0]   width,
    output logic [IDX_W-1:0]   dest
);
    logic [7:0]       opc;
    logic [1:0]       sec_short;
    logic [2:0]       sec_long;
    logic [FLD_W-1:0] imm_pos;
    logic [FLD_W-1:0] imm_width;
    logic [DATA_W-1:0] imm_src;

    always_comb begin
        opc       = instr[7:0];
        sec_short = instr[22:21];
        sec_long  = instr[23:21];
        imm_pos   = instr[27:23];
        imm_width = instr[20:16];
        imm_src   = {{(DATA_W-4){1'b0}}, instr[15:12]};
        dest      = instr[31:28];

        fmt = FMT_NONE;
        unique case (opc)
            OPC_IMM_PW:   if (sec_short == 2'b00) fmt = FMT_IMM_PW;
            OPC_IMM_PAIR: if (sec_long == 3'b000) fmt = FMT_IMM_PAIR;
            OPC_IMM_RW:   if (sec_long == 3'b000) fmt = FMT_IMM_RW;
            OPC_REG_PW:   if (sec_short == 2'b00) fmt = FMT_REG_PW;
            default:      fmt = FMT_NONE;
        endcase
        legal = (fmt != FMT_NONE);

        src   = imm_src;
        pos   = imm_pos;
        width = imm_width;
        case (fmt)
            FMT_IMM_PAIR: begin
                pos   = op_e[FLD_W-1:0];
                width = op_e[DATA_W+FLD_W-1:DATA_W];
            end
            FMT_IMM_RW: begin
                pos = op_d[FLD_W-1:0];
            end
            FMT_REG_PW: begin
                src = op_b;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bfins_merge.sv
module bfins_merge
    import bfins_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter bit MASK_BY_COMPARE = 1'b0,
    localparam int SUM_W          = FLD_W + 1
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] src,
    input  logic [FLD_W-1:0]  pos,
    input  logic [FLD_W-1:0]  width,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] result,
    output logic              oor
);
    logic [SUM_W-1:0] span_end;

    assign span_end = SUM_W'(pos) + SUM_W'(width);

    generate
        if (MASK_BY_COMPARE) begin : g_cmp
            for (genvar i = 0; i < DATA_W; i++) begin : g_bit
                assign mask[i] = (SUM_W'(i) >= SUM_W'(pos)) && (SUM_W'(i) < span_end);
            end
        end else begin : g_shift
            logic [DATA_W-1:0] low_ones;
            assign low_ones = ~({DATA_W{1'b1}} << width);
            assign mask     = low_ones << pos;
        end
    endgenerate

    always_comb begin
        result = (base & ~mask) | ((src << pos) & mask);
        oor    = span_end > SUM_W'(DATA_W);
    end
endmodule

// File: rtl/bfins_unit.sv
module bfins_unit
    import bfins_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter bit MASK_BY_COMPARE = 1'b0,
    localparam int PAIR_W         = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   op_d,
    input  logic [PAIR_W-1:0]   op_e,
    output logic                res_valid,
    output logic [DATA_W-1:0]   res_data,
    output logic [IDX_W-1:0]    res_dest,
    output logic                res_oor,
    output logic                res_illegal
);
    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic              oor;
        logic [IDX_W-1:0]  dest;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic              dec_legal;
    fmt_e              dec_fmt;
    logic [DATA_W-1:0] dec_src;
    logic [FLD_W-1:0]  dec_pos;
    logic [FLD_W-1:0]  dec_width;
    logic [IDX_W-1:0]  dec_dest;
    logic [DATA_W-1:0] mrg_mask;
    logic [DATA_W-1:0] mrg_result;
    logic              mrg_oor;

    bfins_decode #(.DATA_W(DATA_W)) u_decode (
        .instr (instr),
        .op_b  (op_b),
        .op_d  (op_d),
        .op_e  (op_e),
        .legal (dec_legal),
        .fmt   (dec_fmt),
        .src   (dec_src),
        .pos   (dec_pos),
        .width (dec_width),
        .dest  (dec_dest)
    );

    bfins_merge #(.DATA_W(DATA_W), .MASK_BY_COMPARE(MASK_BY_COMPARE)) u_merge (
        .base   (op_a),
        .src    (dec_src),
        .pos    (dec_pos),
        .width  (dec_width),
        .mask   (mrg_mask),
        .result (mrg_result),
        .oor    (mrg_oor)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid && dec_legal;
        st_d.illegal = in_valid && !dec_legal;
        st_d.oor     = in_valid && dec_legal && mrg_oor;
        if (in_valid) begin
            st_d.dest = dec_dest;
            st_d.data = mrg_result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.valid;
    assign res_illegal = st_q.illegal;
    assign res_oor     = st_q.oor;
    assign res_dest    = st_q.dest;
    assign res_data    = st_q.data;

    AST_KEEP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (((mrg_result ^ op_a) & ~mrg_mask) == '0)); // R1
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_width == '0) |-> (mrg_mask == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((mrg_mask & ~({DATA_W{1'b1}} << dec_pos)) == '0)); // R6
    AST_OOR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_oor |-> res_valid); // R6
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_illegal)); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid)); // R8
    AST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_dest == $past(instr[31:28]))); // R8
endmodule

// File: tb/sim_bfins_unit.sv
module sim_bfins_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [31:0] op_a, op_b, op_d;
    logic [63:0] op_e;
    logic        res_valid, res_oor, res_illegal;
    logic [31:0] res_data;
    logic [3:0]  res_dest;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bfins_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .op_a(op_a), .op_b(op_b), .op_d(op_d), .op_e(op_e),
        .res_valid(res_valid), .res_data(res_data), .res_dest(res_dest),
        .res_oor(res_oor), .res_illegal(res_illegal)
    );

    function automatic logic [31:0] ref_ins(logic [31:0] a, logic [31:0] s, int p, int w);
        logic [63:0] m;
        logic [63:0] sh;
        m  = ((64'd1 << w) - 64'd1) << p;
        sh = {32'd0, s} << p;
        return (a & ~m[31:0]) | (sh[31:0] & m[31:0]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] iw, logic [31:0] a, logic [31:0] b,
                         logic [31:0] d, logic [63:0] e);
        @(negedge clk);
        in_valid = 1'b1; instr = iw; op_a = a; op_b = b; op_d = d; op_e = e;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_ok(string req, logic [31:0] iw, logic [31:0] a, logic [31:0] b,
                          logic [31:0] d, logic [63:0] e, logic [31:0] exp, int p, int w);
        issue(iw, a, b, d, e);
        chk(req, res_data, exp);
        chk(req, {31'd0, res_valid}, 32'd1);
        chk(req, {28'd0, res_dest}, {28'd0, iw[31:28]});
        chk(req, {31'd0, res_oor}, {31'd0, (p + w) > 32});
    endtask

    task automatic run_bad(string req, logic [31:0] iw);
        issue(iw, $urandom, $urandom, $urandom, {$urandom, $urandom});
        chk(req, {30'd0, res_valid, res_illegal}, 32'd1);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, d, iw;
        logic [3:0]  k, c;
        rst_n = 1'b0; in_valid = 1'b1; instr = {4'h5, 5'd3, 2'b00, 5'd4, 4'h9, 4'h1, 8'hB7};
        op_a = '0; op_b = '0; op_d = '0; op_e = '0;
        repeat (3) @(negedge clk);
        // R9: reset holds outputs clear even with in_valid high
        chk("R9", {29'd0, res_valid, res_illegal, res_oor}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        for (int p = 0; p < 32; p++) begin
            for (int w = 0; w < 32; w++) begin
                a = $urandom; b = $urandom; d = $urandom; k = 4'($urandom); c = 4'($urandom);
                // R1 / R5 / R6: immediate position and width
                iw = {c, 5'(p), 2'b00, 5'(w), k, 4'h2, 8'hB7};
                run_ok(w == 0 ? "R5" : ((p + w) > 32 ? "R6" : "R1"), iw, a, b, d,
                       {$urandom, $urandom}, ref_ins(a, {28'd0, k}, p, w), p, w);
                // R2: register source
                iw = {c, 5'(p), 2'b00, 5'(w), k, 4'h3, 8'h37};
                run_ok("R2", iw, a, b, d, {$urandom, $urandom}, ref_ins(a, b, p, w), p, w);
                // R3: pair source for width and position, junk in [20:16]
                iw = {c, 4'h6, 3'b000, 5'($urandom), k, 4'h4, 8'h97};
                run_ok("R3", iw, a, b, d,
                       {$urandom() & 32'hFFFF_FFE0 | 32'(w), $urandom() & 32'hFFFF_FFE0 | 32'(p)},
                       ref_ins(a, {28'd0, k}, p, w), p, w);
                // R4: position from d low bits, upper d bits random
                iw = {c, 4'h7, 3'b000, 5'(w), k, 4'h5, 8'hD7};
                run_ok("R4", iw, a, b, ($urandom() & 32'hFFFF_FFE0) | 32'(p),
                       {$urandom, $urandom}, ref_ins(a, {28'd0, k}, p, w), p, w);
            end
        end

        // R6 corner: field ends exactly at bit 31, then one past
        run_ok("R6", {4'h1, 5'd28, 2'b00, 5'd4, 4'hF, 4'h0, 8'hB7}, 32'h0, 0, 0, 0, 32'hF000_0000, 28, 4);
        run_ok("R6", {4'h1, 5'd29, 2'b00, 5'd4, 4'hF, 4'h0, 8'hB7}, 32'h0, 0, 0, 0, 32'hE000_0000, 29, 4);

        // R7: illegal encodings
        run_bad("R7", {4'h1, 5'd3, 2'b01, 5'd4, 4'h1, 4'h0, 8'hB7});
        run_bad("R7", {4'h1, 5'd3, 2'b10, 5'd4, 4'h1, 4'h0, 8'h37});
        run_bad("R7", {4'h1, 4'h2, 3'b100, 5'd4, 4'h1, 4'h0, 8'h97});
        run_bad("R7", {4'h1, 4'h2, 3'b001, 5'd4, 4'h1, 4'h0, 8'hD7});
        run_bad("R7", {4'h1, 4'h2, 3'b000, 5'd4, 4'h1, 4'h0, 8'h17});
        // R7: illegal flag lasts one cycle
        @(negedge clk);
        chk("R7", {30'd0, res_valid, res_illegal}, 32'd0);

        // R8: no request, no result
        chk("R8", {31'd0, res_valid}, 32'd0);

        // R9: reset mid-stream clears a pending result
        @(negedge clk);
        in_valid = 1'b1; instr = {4'h3, 5'd0, 2'b00, 5'd8, 4'hA, 4'h0, 8'hB7};
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", {30'd0, res_valid, res_illegal}, 32'd0);
        in_valid = 1'b0; rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule